// File: doc/BRIEF.md
# Audio Beep Tone Generator

This block makes a square-wave audio tone for alert and keypress sounds. The pitch is picked by a note number that walks up the degrees of a major scale across about two octaves. The tone plays as one burst, as bursts separated by silent gaps that repeat, or without a break. A sample-rate enable paces the block. On each accepted sample tick it writes one signed sample to its output stream. Each sample is either zero or plus or minus a programmed amplitude.

The beep is meant to be mixed into the audio path ahead of a peak limiter. The amplitude input lets the beep level be set below that limiter's threshold. Note, amplitude, mode and burst lengths are captured when each on-period starts. Changing them while a tone sounds does not disturb that tone.

The output is a valid/ready stream. A new sample is produced only on a tick that finds the output register free, meaning it is empty or being drained in the same cycle. A tick that arrives while the sink holds off is dropped, and the generator does not advance for it. The sink therefore slows the tone rather than losing parts of it. The `busy` flag is a plain status pin.

Top module: `beep_tone_gen`

## Requirements
- R1: During and right after reset, `out_valid`, `out_data` and `busy` are all zero.
- R2: A step is a cycle with `sample_en` high and the output register free (`out_valid` low or `out_ready` high). For note n (0..14), let oct = n/7 and d = n%7. The phase increment is floor(BASE_INC*num/den) shifted left by oct. The ratio num/den for d = 0..6 is 1/1, 9/8, 5/4, 4/3, 3/2, 5/3 and 15/8. Note 15 behaves as note 14. The phase is PHASE_W bits wide, is cleared at the start of every on-period, and advances by the increment after each tone sample. Tone sample k is +A when bit PHASE_W-1 of (k*inc mod 2^PHASE_W) is 0, and -A otherwise.
- R3: `mode` is coded 00 off, 01 single, 10 multiple, 11 continuous. From idle, with mode 00 or `beep_en` low, every sample is zero and `busy` stays low. The step that starts a burst emits one zero sample, and tone sample 0 follows on the next step.
- R4: In single mode the tone lasts (on_sel+1)*ON_UNIT samples, and then the output is zero. The block does not play again until a step sees `beep_en` low.
- R5: In multiple mode, with `beep_en` high, on-periods of (on_sel+1)*ON_UNIT tone samples alternate with off-periods of (off_sel+1)*OFF_UNIT zero samples, with no gap between them.
- R6: In multiple mode, if `beep_en` is lowered during an on-period, that period finishes and the block then goes idle. If it is lowered during an off-period, the next step is idle.
- R7: In continuous mode the tone plays on every step while `beep_en` is high, and the on/off selects are ignored. The first step that sees `beep_en` low emits zero and the block goes idle.
- R8: Note, amplitude, mode, on_sel and off_sel are sampled only when an on-period starts. Changing them in mid-period does not alter the current samples.
- R9: `busy` is high exactly while the block is in an on-period or an off-period. In single mode it falls with the last tone sample.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` holds its value and the tone does not advance. The next accepted step continues with the next tone sample.
- R11: When `sample_en` is low the tone does not advance, and an accepted sample clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Sample-rate tick |
| beep_en | input | 1 | Start/stop level |
| mode | input | 2 | 00 off, 01 single, 10 multiple, 11 continuous |
| note | input | 4 | Scale degree index (0..14, 15 clamps to 14) |
| on_sel | input | 4 | On-period length select |
| off_sel | input | 3 | Off-period length select |
| amplitude | input | AMP_W | Tone magnitude A |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Sink accepts the sample |
| out_data | output | AMP_W+1 | Signed output sample |
| busy | output | 1 | In an on- or off-period |

## Verification
A wrong internal state shows up at the ports within one burst. A period counter that is off by one moves the first zero sample, or the first tone sample after a gap, by one step at the first period boundary. A phase that is not cleared, or an increment that is latched at the wrong time, flips the sign pattern of the tone samples within a few steps of a start. A wrong state transition shows as a burst that repeats, a burst cut short, or `busy` disagreeing with the samples on the step where the sequence should change. The bench sweeps every note, every on-length and every off-length against a closed-form sample formula.

// File: rtl/beep_pkg.sv
package beep_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_MULTI  = 2'b10,
    MODE_CONT   = 2'b11
  } beep_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ON,
    ST_OFF,
    ST_SPENT
  } beep_state_e;

  localparam int NOTE_COUNT  = 15;
  localparam int DEGREES     = 7;
  localparam int ON_CHOICES  = 16;
  localparam int OFF_CHOICES = 8;

  // Just-intonation major scale, one rational ratio per degree.
  function automatic int unsigned note_inc(input int unsigned base, input int unsigned idx);
    int unsigned n, num, den;
    n = (idx >= NOTE_COUNT) ? NOTE_COUNT - 1 : idx;
    case (n % DEGREES)
      0: begin num = 1;  den = 1; end
      1: begin num = 9;  den = 8; end
      2: begin num = 5;  den = 4; end
      3: begin num = 4;  den = 3; end
      4: begin num = 3;  den = 2; end
      5: begin num = 5;  den = 3; end
      default: begin num = 15; den = 8; end
    endcase
    return ((base * num) / den) << (n / DEGREES);
  endfunction
endpackage

// File: rtl/beep_pitch_lut.sv
module beep_pitch_lut #(
  parameter int PHASE_W  = 16,
  parameter int BASE_INC = 720
) (
  input  logic [3:0]         note,
  output logic [PHASE_W-1:0] inc
);
  localparam int LAST = beep_pkg::NOTE_COUNT - 1;

  logic [PHASE_W-1:0] tbl [beep_pkg::NOTE_COUNT];
  logic [3:0]         sel;

  generate
    for (genvar g = 0; g < beep_pkg::NOTE_COUNT; g++) begin : g_note
      assign tbl[g] = PHASE_W'(beep_pkg::note_inc(BASE_INC, g));
    end
  endgenerate

  assign sel = (note > 4'(LAST)) ? 4'(LAST) : note;
  assign inc = tbl[sel];
endmodule

// File: rtl/beep_osc.sv
module beep_osc #(
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                load,
  input  logic                sound,
  input  logic [PHASE_W-1:0]  inc_in,
  input  logic [AMP_W-1:0]    amp_in,
  output logic signed [AMP_W:0] sample
);
  logic [PHASE_W-1:0] phase_q, inc_q;
  logic [AMP_W-1:0]   amp_q;
  logic signed [AMP_W:0] mag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      inc_q   <= '0;
      amp_q   <= '0;
    end else if (step) begin
      if (load) begin
        phase_q <= '0;
        inc_q   <= inc_in;
        amp_q   <= amp_in;
      end else if (sound) begin
        phase_q <= phase_q + inc_q;
      end
    end
  end

  assign mag    = $signed({1'b0, amp_q});
  assign sample = !sound ? '0 : (phase_q[PHASE_W-1] ? -mag : mag);

  // A burst never starts and sounds in the same step (R8: capture before play).
  assert_load_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step && load |-> !sound);
  // The first sample after a capture has a clear phase, so it is never negative (R2).
  assert_first_positive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step && load |=> !(sound && sample < 0));
endmodule

// File: rtl/beep_seq.sv
module beep_seq #(
  parameter int ON_UNIT  = 2400,
  parameter int OFF_UNIT = 4800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic [$clog2(beep_pkg::ON_CHOICES)-1:0]  on_sel,
  input  logic [$clog2(beep_pkg::OFF_CHOICES)-1:0] off_sel,
  output logic       load,
  output logic       sound,
  output logic       busy
);
  import beep_pkg::*;

  localparam int ON_MAX  = ON_CHOICES * ON_UNIT;
  localparam int OFF_MAX = OFF_CHOICES * OFF_UNIT;
  localparam int LEN_MAX = (ON_MAX > OFF_MAX) ? ON_MAX : OFF_MAX;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);

  beep_state_e       state_q, state_d;
  beep_mode_e        mode_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d, on_len_q, off_len_q, on_len_in, off_len_in;
  logic              on_last, off_last;

  assign on_len_in  = CNT_W'((int'(on_sel) + 1) * ON_UNIT);
  assign off_len_in = CNT_W'((int'(off_sel) + 1) * OFF_UNIT);
  assign on_last    = (cnt_q == on_len_q - 1'b1);
  assign off_last   = (cnt_q == off_len_q - 1'b1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    sound   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (en && mode != MODE_OFF) begin
          load    = 1'b1;
          state_d = ST_ON;
          cnt_d   = '0;
        end
      end
      ST_ON: begin
        if (mode_q == MODE_CONT) begin
          sound = en;
          if (!en) state_d = ST_IDLE;
        end else begin
          sound = 1'b1;
          if (on_last) begin
            cnt_d = '0;
            if (mode_q == MODE_SINGLE) state_d = ST_SPENT;
            else if (en)               state_d = ST_OFF;
            else                       state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_OFF: begin
        if (!en) begin
          state_d = ST_IDLE;
        end else if (off_last) begin
          cnt_d = '0;
          if (mode != MODE_OFF) begin
            load    = 1'b1;
            state_d = ST_ON;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SPENT: if (!en) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_q    <= MODE_OFF;
      cnt_q     <= '0;
      on_len_q  <= '0;
      off_len_q <= '0;
    end else if (step) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (load) begin
        mode_q    <= beep_mode_e'(mode);
        on_len_q  <= on_len_in;
        off_len_q <= off_len_in;
      end
    end
  end

  assign busy = (state_q == ST_ON) || (state_q == ST_OFF);

  assert_on_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_ON && mode_q != MODE_CONT |-> cnt_q < on_len_q);
  assert_off_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_OFF |-> cnt_q < off_len_q && mode_q == MODE_MULTI);
  assert_spent_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_SPENT |-> mode_q == MODE_SINGLE);
  assert_off_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step && state_q == ST_OFF && !en |=> state_q == ST_IDLE);
endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen #(
  parameter int PHASE_W  = 16,
  parameter int BASE_INC = 720,
  parameter int ON_UNIT  = 2400,
  parameter int OFF_UNIT = 4800,
  parameter int AMP_W    = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_en,
  input  logic                  beep_en,
  input  logic [1:0]            mode,
  input  logic [3:0]            note,
  input  logic [3:0]            on_sel,
  input  logic [2:0]            off_sel,
  input  logic [AMP_W-1:0]      amplitude,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic signed [AMP_W:0] out_data,
  output logic                  busy
);
  logic                  step, load, sound;
  logic [PHASE_W-1:0]    inc;
  logic signed [AMP_W:0] sample;

  assign step = sample_en && (!out_valid || out_ready);

  beep_pitch_lut #(.PHASE_W(PHASE_W), .BASE_INC(BASE_INC)) u_lut (
    .note (note),
    .inc  (inc)
  );

  beep_seq #(.ON_UNIT(ON_UNIT), .OFF_UNIT(OFF_UNIT)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .en      (beep_en),
    .mode    (mode),
    .on_sel  (on_sel),
    .off_sel (off_sel),
    .load    (load),
    .sound   (sound),
    .busy    (busy)
  );

  beep_osc #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_osc (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .load   (load),
    .sound  (sound),
    .inc_in (inc),
    .amp_in (amplitude),
    .sample (sample)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (step) begin
      out_valid <= 1'b1;
      out_data  <= sample;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step && !sound |=> out_data == 0);
  assert_idle_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en && out_ready |=> !out_valid);
endmodule

// File: tb/test_beep_tone_gen.sv
module test_beep_tone_gen;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n, sample_en, beep_en, out_ready;
  logic [1:0] mode;
  logic [3:0] note, on_sel;
  logic [2:0] off_sel;
  logic [AW-1:0] amplitude;
  logic out_valid, busy;
  logic signed [AW:0] out_data;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  beep_tone_gen #(.PHASE_W(8), .BASE_INC(8), .ON_UNIT(3), .OFF_UNIT(2), .AMP_W(AW)) i_beep_tone_gen (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .beep_en(beep_en), .mode(mode),
    .note(note), .on_sel(on_sel), .off_sel(off_sel), .amplitude(amplitude),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .busy(busy)
  );

  function automatic int exp_inc(input int n);
    int m;
    int num [7] = '{1, 9, 5, 4, 3, 5, 15};
    int den [7] = '{1, 8, 4, 3, 2, 3, 8};
    m = (n > 14) ? 14 : n;
    return ((8 * num[m % 7]) / den[m % 7]) * (1 << (m / 7));
  endfunction

  function automatic int tone(input int n, input int k, input int a);
    int ph;
    ph = (k * exp_inc(n)) % 256;
    return (ph >= 128) ? -a : a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_data(input string req, input int exp);
    chk(int'(out_data) == exp, req, int'(out_data), exp);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; sample_en = 1'b1; beep_en = 1'b0; out_ready = 1'b1;
    mode = 2'b00; note = 4'd0; on_sel = 4'd0; off_sel = 3'd0; amplitude = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk_data("R1 data", 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    rst_n = 1'b1;

    // R3: mode off never starts
    beep_en = 1'b1; amplitude = 7'd100;
    for (int i = 0; i < 8; i++) begin
      tick();
      chk_data("R3 off mode", 0);
      chk(busy == 1'b0, "R3 off busy", int'(busy), 0);
    end
    beep_en = 1'b0; tick();

    // R2/R4/R9: every note, single mode, longest on-period
    mode = 2'b01; on_sel = 4'd15;
    for (int n = 0; n < 16; n++) begin
      note = 4'(n); beep_en = 1'b1;
      tick(); chk_data("R3 start zero", 0);
      for (int k = 0; k < 48; k++) begin
        tick();
        chk_data("R2 pitch", tone(n, k, 100));
        chk(busy == (k < 47), "R9 busy", int'(busy), int'(k < 47));
      end
      repeat (2) begin
        tick(); chk_data("R4 no retrigger", 0);
        chk(busy == 1'b0, "R4 busy low", int'(busy), 0);
      end
      beep_en = 1'b0; tick(); tick();
    end

    // R4: every on-length
    note = 4'd3; amplitude = 7'd50;
    for (int s = 0; s < 16; s++) begin
      int cnt;
      cnt = 0;
      on_sel = 4'(s); beep_en = 1'b1;
      tick();
      for (int t = 0; t < (s + 1) * 3 + 3; t++) begin
        tick();
        if (out_data != 0) cnt++;
      end
      chk(cnt == (s + 1) * 3, "R4 on length", cnt, (s + 1) * 3);
      chk(busy == 1'b0, "R4 busy after", int'(busy), 0);
      beep_en = 1'b0; tick(); tick();
    end

    // R5/R6: every off-length, multiple mode
    mode = 2'b10; on_sel = 4'd1; note = 4'd4; amplitude = 7'd40;
    for (int o = 0; o < 8; o++) begin
      int per;
      per = 6 + (o + 1) * 2;
      off_sel = 3'(o); beep_en = 1'b1;
      tick(); chk_data("R3 start zero", 0);
      for (int t = 0; t < 2 * per; t++) begin
        tick();
        chk_data("R5 pattern", ((t % per) < 6) ? tone(4, t % per, 40) : 0);
        chk(busy == 1'b1, "R9 busy multi", int'(busy), 1);
      end
      tick(); chk_data("R5 third", tone(4, 0, 40));
      tick(); chk_data("R5 third", tone(4, 1, 40));
      beep_en = 1'b0;
      for (int k = 2; k < 6; k++) begin
        tick(); chk_data("R6 finish on", tone(4, k, 40));
      end
      chk(busy == 1'b0, "R6 idle after on", int'(busy), 0);
      tick(); chk_data("R6 zero after", 0);
    end

    // R6: stop inside off-period, then restart from idle
    on_sel = 4'd0; off_sel = 3'd7; beep_en = 1'b1;
    tick();
    for (int k = 0; k < 3; k++) begin tick(); chk_data("R5 short on", tone(4, k, 40)); end
    tick(); chk_data("R5 off zero", 0);
    beep_en = 1'b0;
    tick(); chk_data("R6 off stop", 0);
    chk(busy == 1'b0, "R6 off stop busy", int'(busy), 0);
    note = 4'd6; beep_en = 1'b1;
    tick(); chk_data("R6 restart zero", 0);
    tick(); chk_data("R6 restart tone", tone(6, 0, 40));
    beep_en = 1'b0; repeat (4) tick();

    // R8: changes mid-period wait for next on-period
    on_sel = 4'd1; off_sel = 3'd0; note = 4'd0; amplitude = 7'd60; beep_en = 1'b1;
    tick();
    tick(); chk_data("R8 old", tone(0, 0, 60));
    tick(); chk_data("R8 old", tone(0, 1, 60));
    note = 4'd9; amplitude = 7'd30;
    for (int k = 2; k < 6; k++) begin tick(); chk_data("R8 held note", tone(0, k, 60)); end
    for (int k = 0; k < 2; k++) begin tick(); chk_data("R8 gap", 0); end
    for (int k = 0; k < 6; k++) begin tick(); chk_data("R8 new note", tone(9, k, 30)); end
    beep_en = 1'b0; repeat (3) tick();

    // R7: continuous ignores durations and mid-run changes (R8)
    mode = 2'b11; on_sel = 4'd0; note = 4'd5; amplitude = 7'd70; beep_en = 1'b1;
    tick();
    for (int k = 0; k < 40; k++) begin
      if (k == 11) begin mode = 2'b01; note = 4'd12; end
      tick();
      chk_data("R7 continuous", tone(5, k, 70));
      chk(busy == 1'b1, "R9 busy cont", int'(busy), 1);
    end
    beep_en = 1'b0;
    tick(); chk_data("R7 stop zero", 0);
    chk(busy == 1'b0, "R7 stop busy", int'(busy), 0);

    // R10/R11: back-pressure and tick gating
    mode = 2'b11; note = 4'd2; amplitude = 7'd90; beep_en = 1'b1;
    tick();
    for (int k = 0; k < 5; k++) begin tick(); chk_data("R10 pre", tone(2, k, 90)); end
    out_ready = 1'b0;
    repeat (4) begin
      tick();
      chk_data("R10 hold", tone(2, 4, 90));
      chk(out_valid == 1'b1, "R10 valid held", int'(out_valid), 1);
    end
    out_ready = 1'b1;
    tick(); chk_data("R10 resume", tone(2, 5, 90));
    sample_en = 1'b0;
    tick(); chk(out_valid == 1'b0, "R11 valid drop", int'(out_valid), 0);
    tick(); tick();
    sample_en = 1'b1;
    tick(); chk_data("R11 resume", tone(2, 6, 90));
    chk(out_valid == 1'b1, "R11 valid back", int'(out_valid), 1);
    beep_en = 1'b0; tick();

    summary();
    $finish;
  end
endmodule